// File: doc/BRIEF.md
# Parameter Block Fetch Engine

This engine lets software start a read or write operation with a single register write. It does not need to write the channel, size, address and command one register at a time. Software first places a 24-byte parameter block in memory and programs the block's physical base address once, through two 32-bit halves. After that, writing any value to the trigger register starts a full cycle:

- the engine reads the four input words of the block over a word-wide memory master port;
- if the command is one it supports, it hands the operation to a backend over a request/response port;
- it stores the backend's return value in the block's result word.

Commands it does not recognise are answered at once with a fixed error code, and the backend is never called for them.

The block layout is six 32-bit words at byte offsets 0 to 20:

| Offset | Word |
|---|---|
| 0 | channel |
| 4 | size |
| 8 | buffer address |
| 12 | command |
| 16 | result |
| 20 | reserved flags |

The engine never touches the flags word. A one-cycle `done` pulse marks the end of each operation. A trigger that arrives while the engine is busy is lost, and this is recorded in a sticky flag.

Top module: `pblk_engine`

## Requirements
- R1: After reset `busy`, `mem_req`, `be_req`, `done` and `overrun` are all low.
- R2: A write with `cfg_sel`=0 sets the low 32 bits of the block base, and `cfg_sel`=1 sets the high 32 bits. Every memory address the engine issues is this 64-bit base plus a byte offset.
- R3: A write with `cfg_sel`=2 in the idle state starts an operation whatever `cfg_wdata` holds. `busy` is high from the next cycle on.
- R4: The engine issues exactly four reads (`mem_we`=0), in order, at base+0, base+4, base+8 and base+12. These return channel, size, buffer address and command.
- R5: When the command word is 1 (read buffer) or 2 (write buffer), `be_req` carries the fetched channel, size, address and command on `be_chan`, `be_size`, `be_addr` and `be_cmd`.
- R6: The engine issues exactly one write (`mem_we`=1), at base+16, carrying the `be_result` value received with `be_rsp_valid`. It never accesses base+20.
- R7: Any other command value causes no backend request. The engine writes 32'hFFFF_FFEA (-22) to base+16 instead.
- R8: `done` is high for exactly one cycle: the cycle after the result write is accepted by `mem_ack`. There is one pulse per operation.
- R9: A trigger write while `busy` is high starts nothing and sets `overrun`. `overrun` then stays high until reset.
- R10: The base address is captured when an operation starts. Base register writes during an operation only affect later operations.
- R11: Once raised, `mem_req` with its address, direction and data is held until `mem_ack`. `be_req` with its fields is held until `be_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 base low, 1 base high, 2 trigger |
| cfg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory direction, 1 = write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory accepts request; read data valid this cycle |
| mem_rdata | input | 32 | Memory read data |
| be_req | output | 1 | Backend request |
| be_cmd | output | 32 | Command word |
| be_chan | output | 32 | Channel word |
| be_size | output | 32 | Buffer size word |
| be_addr | output | 32 | Buffer address word |
| be_ready | input | 1 | Backend accepts request |
| be_rsp_valid | input | 1 | Backend result valid |
| be_result | input | 32 | Backend result value |
| done | output | 1 | Operation complete pulse |
| busy | output | 1 | Operation in progress |
| overrun | output | 1 | Sticky flag: trigger arrived while busy |

## Verification
The bench uses a base whose high half is non-zero. A design that drops `cfg_sel`=1, or adds the offsets with only 32 bits, then sends its reads to the wrong place. It also rewrites the base low half in the middle of an operation, which catches an engine that reads the live register and splits one block across two addresses. An unknown command must reach memory as -22 without any backend request, or the backend model reports an unexpected request. A second trigger sent during the fetch must raise `overrun` without adding accesses, which catches an engine that queues or restarts instead of dropping. The memory model varies its accept latency, so address drift during a held request and a mistimed or repeated `done` both show up against the scoreboard.

// File: rtl/pblk_pkg.sv
package pblk_pkg;

   localparam int unsigned PB_WORD_BYTES = 4;
   localparam int unsigned PB_NFETCH     = 4;
   localparam int unsigned PB_IDX_W      = 3;

   // word positions inside the block; the fetch order follows them
   localparam logic [PB_IDX_W-1:0] PB_IDX_CHAN   = 3'd0;
   localparam logic [PB_IDX_W-1:0] PB_IDX_SIZE   = 3'd1;
   localparam logic [PB_IDX_W-1:0] PB_IDX_BUF    = 3'd2;
   localparam logic [PB_IDX_W-1:0] PB_IDX_CMD    = 3'd3;
   localparam logic [PB_IDX_W-1:0] PB_IDX_RESULT = 3'd4;

   localparam logic [31:0] PB_OP_READ    = 32'd1;
   localparam logic [31:0] PB_OP_WRITE   = 32'd2;
   localparam logic [31:0] PB_ERR_BADCMD = 32'hFFFF_FFEA;

   localparam logic [1:0] PB_SEL_BASE_LO = 2'd0;
   localparam logic [1:0] PB_SEL_BASE_HI = 2'd1;
   localparam logic [1:0] PB_SEL_TRIGGER = 2'd2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_ISSUE,
      ST_WAIT,
      ST_WBACK
   } pb_state_e;

   function automatic logic pb_op_legal(input logic [31:0] code);
      return (code == PB_OP_READ) || (code == PB_OP_WRITE);
   endfunction

endpackage

// File: rtl/pblk_cfg.sv
module pblk_cfg
   import pblk_pkg::*;
#(
   parameter int unsigned ADDR_W = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [1:0]  cfg_sel,
   input  logic [31:0] cfg_wdata,
   input  logic        busy,
   output logic [63:0] base,
   output logic        trig,
   output logic        overrun
);

   logic [31:0] lo_q;
   logic [31:0] hi_q;
   logic        ovr_q;

   assign trig = cfg_we && (cfg_sel == PB_SEL_TRIGGER);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= '0;
      end else if (cfg_we && (cfg_sel == PB_SEL_BASE_LO)) begin
         lo_q <= cfg_wdata;
      end
   end

   generate
      if (ADDR_W > 32) begin : g_hi_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hi_q <= '0;
            end else if (cfg_we && (cfg_sel == PB_SEL_BASE_HI)) begin
               hi_q <= cfg_wdata;
            end
         end
      end else begin : g_hi_none
         assign hi_q = '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovr_q <= 1'b0;
      end else if (trig && busy) begin
         ovr_q <= 1'b1;
      end
   end

   assign base    = {hi_q, lo_q};
   assign overrun = ovr_q;

   // R9
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   // R9
   ovr_on_busy_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == PB_SEL_TRIGGER && busy) |=> overrun);

endmodule

// File: rtl/pblk_addr.sv
module pblk_addr
   import pblk_pkg::*;
#(
   parameter int unsigned ADDR_W = 64
) (
   input  logic [63:0]         base,
   input  logic [PB_IDX_W-1:0] word_idx,
   output logic [ADDR_W-1:0]   addr
);

   localparam int unsigned OFS_W = PB_IDX_W + $clog2(PB_WORD_BYTES);

   logic [OFS_W-1:0] ofs;

   assign ofs = {word_idx, {($clog2(PB_WORD_BYTES)){1'b0}}};

   generate
      if (ADDR_W == 64) begin : g_wide
         assign addr = base + {{(64-OFS_W){1'b0}}, ofs};
      end else begin : g_narrow
         assign addr = base[ADDR_W-1:0] + {{(ADDR_W-OFS_W){1'b0}}, ofs};
      end
   endgenerate

endmodule

// File: rtl/pblk_seq.sv
module pblk_seq
   import pblk_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                trig,
   input  logic [63:0]         base,
   output logic [63:0]         base_q,
   output logic [PB_IDX_W-1:0] word_idx,
   output logic                mem_req,
   output logic                mem_we,
   output logic [31:0]         mem_wdata,
   input  logic                mem_ack,
   input  logic [31:0]         mem_rdata,
   output logic                be_req,
   output logic [31:0]         be_cmd,
   output logic [31:0]         be_chan,
   output logic [31:0]         be_size,
   output logic [31:0]         be_addr,
   input  logic                be_ready,
   input  logic                be_rsp_valid,
   input  logic [31:0]         be_result,
   output logic                done,
   output logic                busy
);

   pb_state_e           st_q;
   logic [PB_IDX_W-1:0] idx_q;
   logic [31:0]         res_q;
   logic                done_q;
   logic [31:0]         fld_q [PB_NFETCH];
   logic                cap;

   assign cap = (st_q == ST_FETCH) && mem_ack;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         idx_q  <= '0;
         res_q  <= '0;
         done_q <= 1'b0;
         base_q <= '0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (trig) begin
                  base_q <= base;
                  idx_q  <= PB_IDX_CHAN;
                  st_q   <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (mem_ack) begin
                  if (idx_q == PB_IDX_CMD) begin
                     if (pb_op_legal(mem_rdata)) begin
                        st_q <= ST_ISSUE;
                     end else begin
                        res_q <= PB_ERR_BADCMD;
                        st_q  <= ST_WBACK;
                     end
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            ST_ISSUE: begin
               if (be_ready) st_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (be_rsp_valid) begin
                  res_q <= be_result;
                  st_q  <= ST_WBACK;
               end
            end
            ST_WBACK: begin
               if (mem_ack) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   generate
      for (genvar g = 0; g < PB_NFETCH; g++) begin : g_fld
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               fld_q[g] <= '0;
            end else if (cap && (idx_q == PB_IDX_W'(g))) begin
               fld_q[g] <= mem_rdata;
            end
         end
      end
   endgenerate

   assign word_idx  = (st_q == ST_WBACK) ? PB_IDX_RESULT : idx_q;
   assign mem_req   = (st_q == ST_FETCH) || (st_q == ST_WBACK);
   assign mem_we    = (st_q == ST_WBACK);
   assign mem_wdata = res_q;
   assign be_req    = (st_q == ST_ISSUE);
   assign be_chan   = fld_q[PB_IDX_CHAN[1:0]];
   assign be_size   = fld_q[PB_IDX_SIZE[1:0]];
   assign be_addr   = fld_q[PB_IDX_BUF[1:0]];
   assign be_cmd    = fld_q[PB_IDX_CMD[1:0]];
   assign done      = done_q;
   assign busy      = (st_q != ST_IDLE);

   // R7
   be_cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      be_req |-> (be_cmd == PB_OP_READ || be_cmd == PB_OP_WRITE));

   // R11
   be_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (be_req && !be_ready) |=> (be_req && $stable(be_cmd) && $stable(be_chan)
                                  && $stable(be_size) && $stable(be_addr)));

   // R8
   done_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(mem_req && mem_we && mem_ack));

   // R10
   base_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(base_q));

endmodule

// File: rtl/pblk_engine.sv
module pblk_engine
   import pblk_pkg::*;
#(
   parameter int unsigned ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [31:0]       cfg_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic              be_req,
   output logic [31:0]       be_cmd,
   output logic [31:0]       be_chan,
   output logic [31:0]       be_size,
   output logic [31:0]       be_addr,
   input  logic              be_ready,
   input  logic              be_rsp_valid,
   input  logic [31:0]       be_result,
   output logic              done,
   output logic              busy,
   output logic              overrun
);

   generate
      if (ADDR_W < 32 || ADDR_W > 64) begin : g_bad_addr_w
         $error("pblk_engine: ADDR_W must lie in 32..64");
      end
   endgenerate

   logic [63:0]         cfg_base;
   logic [63:0]         run_base;
   logic                trig;
   logic [PB_IDX_W-1:0] word_idx;

   pblk_cfg #(.ADDR_W(ADDR_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .busy      (busy),
      .base      (cfg_base),
      .trig      (trig),
      .overrun   (overrun)
   );

   pblk_seq u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .trig         (trig),
      .base         (cfg_base),
      .base_q       (run_base),
      .word_idx     (word_idx),
      .mem_req      (mem_req),
      .mem_we       (mem_we),
      .mem_wdata    (mem_wdata),
      .mem_ack      (mem_ack),
      .mem_rdata    (mem_rdata),
      .be_req       (be_req),
      .be_cmd       (be_cmd),
      .be_chan      (be_chan),
      .be_size      (be_size),
      .be_addr      (be_addr),
      .be_ready     (be_ready),
      .be_rsp_valid (be_rsp_valid),
      .be_result    (be_result),
      .done         (done),
      .busy         (busy)
   );

   pblk_addr #(.ADDR_W(ADDR_W)) u_addr (
      .base     (run_base),
      .word_idx (word_idx),
      .addr     (mem_addr)
   );

   // R11
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                  && $stable(mem_wdata)));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !be_req));

endmodule

// File: tb/sim_pblk_engine.sv
module sim_pblk_engine;
   import pblk_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [31:0] cfg_wdata = 32'd0;
   logic        mem_req, mem_we;
   logic [63:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = 32'd0;
   logic        be_req;
   logic [31:0] be_cmd, be_chan, be_size, be_addr;
   logic        be_ready = 1'b0;
   logic        be_rsp_valid = 1'b0;
   logic [31:0] be_result = 32'd0;
   logic        done, busy, overrun;

   int checks = 0;
   int errors = 0;
   int ops = 0;
   int done_cnt = 0;
   int mlat = 0;
   int mwait = 0;
   logic        last_we = 1'b0;
   logic [63:0] hold_addr = 64'd0;
   logic [63:0] cur_base = 64'd0;
   logic [63:0] op_base = 64'd0;
   logic [31:0] op_flag = 32'd0;
   logic [31:0] op_res = 32'd0;

   logic [31:0]  mem [logic [63:0]];
   logic [96:0]  exp_mem [$];
   logic [127:0] exp_be [$];

   always #10 clk = ~clk;

   pblk_engine #(.ADDR_W(64)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .be_req(be_req), .be_cmd(be_cmd), .be_chan(be_chan), .be_size(be_size), .be_addr(be_addr),
      .be_ready(be_ready), .be_rsp_valid(be_rsp_valid), .be_result(be_result),
      .done(done), .busy(busy), .overrun(overrun)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] be_model(input logic [31:0] c, input logic [31:0] s,
                                            input logic [31:0] a, input logic [31:0] k);
      return (c ^ a) + s + {k[7:0], 24'h0};
   endfunction

   function automatic logic [31:0] rd_mem(input logic [63:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   // memory model and scoreboard monitor for memory traffic
   initial begin
      forever begin
         @(negedge clk);
         if (mem_ack) begin
            mem_ack = 1'b0;
            // R8: done follows the accepted result write by one cycle
            if (last_we) chk(done === 1'b1, "R8", "done after write-back", {63'd0, done}, 64'd1);
         end else if (rst_n && mem_req) begin
            // R11: request held while not accepted
            if (mwait > 0) chk(mem_addr == hold_addr, "R11", "held address", mem_addr, hold_addr);
            else hold_addr = mem_addr;
            if (mwait < mlat) begin
               mwait++;
            end else begin
               mwait = 0;
               mlat  = (mlat + 1) % 3;
               if (exp_mem.size() == 0) begin
                  chk(1'b0, "R4", "unexpected memory access", mem_addr, 64'd0);
               end else begin
                  logic [96:0] e;
                  e = exp_mem.pop_front();
                  chk(mem_we == e[96] && mem_addr == e[95:32], e[96] ? "R6" : "R2/R4",
                      "access address", {mem_addr[62:0], mem_we}, {e[94:32], e[96]});
                  if (mem_we) chk(mem_wdata == e[31:0], "R6", "result value", {32'd0, mem_wdata}, {32'd0, e[31:0]});
               end
               if (mem_we) mem[mem_addr] = mem_wdata;
               else mem_rdata = rd_mem(mem_addr);
               last_we = mem_we;
               mem_ack = 1'b1;
            end
         end
      end
   end

   // backend model and scoreboard monitor for backend requests
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && be_req) begin
            logic [31:0] rsp;
            if (exp_be.size() == 0) begin
               chk(1'b0, "R7", "unexpected backend request", {32'd0, be_cmd}, 64'd0);
            end else begin
               logic [127:0] b;
               b = exp_be.pop_front();
               chk({be_chan, be_size} == b[127:64], "R5", "channel/size", {be_chan, be_size}, b[127:64]);
               chk({be_addr, be_cmd} == b[63:0], "R5", "address/command", {be_addr, be_cmd}, b[63:0]);
            end
            rsp = be_model(be_chan, be_size, be_addr, be_cmd);
            be_ready = 1'b1;
            @(negedge clk);
            be_ready = 1'b0;
            @(negedge clk);
            be_result = rsp;
            be_rsp_valid = 1'b1;
            @(negedge clk);
            be_rsp_valid = 1'b0;
         end
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && done) done_cnt++;
      end
   end

   task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_sel = sel;
      cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_base(input logic [63:0] b);
      cfg_write(PB_SEL_BASE_LO, b[31:0]);
      cfg_write(PB_SEL_BASE_HI, b[63:32]);
      cur_base = b;
   endtask

   // driver: fills the block, pushes expectations, fires the trigger
   task automatic start_op(input logic [31:0] c, input logic [31:0] s, input logic [31:0] a,
                           input logic [31:0] k, input logic [31:0] trigval, input logic [31:0] flag);
      op_base = cur_base;
      op_flag = flag;
      mem[op_base]      = c;
      mem[op_base + 4]  = s;
      mem[op_base + 8]  = a;
      mem[op_base + 12] = k;
      mem[op_base + 16] = 32'h0BAD_0BAD;
      mem[op_base + 20] = flag;
      for (int i = 0; i < 4; i++) exp_mem.push_back({1'b0, op_base + 64'(4 * i), 32'd0});
      if (k == PB_OP_READ || k == PB_OP_WRITE) begin
         op_res = be_model(c, s, a, k);
         exp_be.push_back({c, s, a, k});
      end else begin
         op_res = 32'hFFFF_FFEA;
      end
      exp_mem.push_back({1'b1, op_base + 64'd16, op_res});
      cfg_write(PB_SEL_TRIGGER, trigval);
      ops++;
      // R3: any trigger value starts the engine
      chk(busy === 1'b1, "R3", "busy after trigger", {63'd0, busy}, 64'd1);
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(rd_mem(op_base + 16) == op_res, "R6", "result word", {32'd0, rd_mem(op_base + 16)}, {32'd0, op_res});
      chk(rd_mem(op_base + 20) == op_flag, "R6", "flags untouched", {32'd0, rd_mem(op_base + 20)}, {32'd0, op_flag});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(!busy && !mem_req && !be_req, "R1", "idle after reset", {61'd0, busy, mem_req, be_req}, 64'd0);
      chk(!done && !overrun, "R1", "flags after reset", {62'd0, done, overrun}, 64'd0);

      // R2, R4, R5, R6: write-buffer command, high half of base non-zero, trigger value zero
      set_base(64'h0000_0001_0000_1000);
      start_op(32'd5, 32'd64, 32'h0000_ABC0, PB_OP_WRITE, 32'h0, 32'hF1A6_0001);
      wait_idle();

      // R3, R5: read-buffer command with an all-ones trigger value
      start_op(32'h0000_0102, 32'd4096, 32'h7FFF_F000, PB_OP_READ, 32'hFFFF_FFFF, 32'hF1A6_0002);
      wait_idle();

      // R7: unknown command goes straight to the error code
      start_op(32'd9, 32'd8, 32'h0000_2000, 32'd9, 32'h55, 32'hF1A6_0003);
      wait_idle();
      start_op(32'd9, 32'd8, 32'h0000_2000, 32'd0, 32'h56, 32'hF1A6_0004);
      wait_idle();

      // R10: base rewrite during the fetch leaves the running operation alone
      start_op(32'd11, 32'd12, 32'h0000_3000, PB_OP_WRITE, 32'h1, 32'hF1A6_0005);
      cfg_write(PB_SEL_BASE_LO, 32'h0000_2000);
      wait_idle();
      cur_base = 64'h0000_0001_0000_2000;
      start_op(32'd13, 32'd14, 32'h0000_4000, PB_OP_READ, 32'h2, 32'hF1A6_0006);
      wait_idle();

      // R9: trigger while busy is dropped and latches the overrun flag
      chk(overrun === 1'b0, "R9", "overrun clear before", {63'd0, overrun}, 64'd0);
      start_op(32'd21, 32'd22, 32'h0000_5000, PB_OP_WRITE, 32'h3, 32'hF1A6_0007);
      cfg_write(PB_SEL_TRIGGER, 32'h4);
      chk(overrun === 1'b1, "R9", "overrun set", {63'd0, overrun}, 64'd1);
      wait_idle();
      repeat (6) @(negedge clk);
      chk(!busy && !mem_req, "R9", "dropped trigger started nothing", {62'd0, busy, mem_req}, 64'd0);
      chk(overrun === 1'b1, "R9", "overrun sticky", {63'd0, overrun}, 64'd1);

      // end-of-run scoreboard checks
      chk(done_cnt == ops, "R8", "done pulse count", 64'(done_cnt), 64'(ops));
      chk(exp_mem.size() == 0, "R6", "memory accesses left over", 64'(exp_mem.size()), 64'd0);
      chk(exp_be.size() == 0, "R5", "backend requests left over", 64'(exp_be.size()), 64'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule